// File: doc/BRIEF.md
# Illegal access event controller

This block collects single-cycle illegal-access pulses from a set of protected resources, such as peripheral gates and memory firewalls, and reports them to the trusted processor. Each source has an enable bit. A pulse from an enabled source sets that source's pending bit. The interrupt output stays high while any source is both pending and enabled.

Besides the pending flags, the block records the details of the first fault that has not yet been serviced: the source index, the offender's compartment identifier, its secure and privilege flags, and whether it was a write. The record holds until software has cleared every pending bit, so later faults cannot hide the one that started the episode.

Software reaches the block through a small register port. Only the trusted compartment, whose identifier is fixed by a parameter, may change or observe anything. Any other compartment's writes are dropped, and its reads return zero.

Top module: `access_fault_ctrl`

## Requirements
- R1: After reset, the enable register, the pending register and the detail word read as zero, and `irq` is low.
- R2: A pulse on `src_evt[i]` sets pending bit i on the next clock edge only while enable bit i is set. A pulse on a disabled source leaves the pending register unchanged.
- R3: `irq` is high exactly when some bit is set in both the pending and the enable registers. Clearing an enable bit masks that source's interrupt but keeps its pending bit.
- R4: A write to the pending register (word address 1) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R5: The detail word (word address 2) holds the first fault taken while no bit was pending. Its layout is: bits [7:0] source index, bits [15:8] CID, bit 16 secure, bit 17 privileged, bit 18 write, bit 31 valid. Faults that arrive while any bit is still pending do not change it.
- R6: When several enabled sources pulse in the same cycle and nothing is pending, the detail word records the lowest-numbered of them.
- R7: When the pending register becomes all zero, the detail word reads zero. A fault that arrives in the same cycle as the clear that empties the register is captured as a new first fault.
- R8: Requests whose `req_cid` differs from the trusted CID change no register, and their reads return zero.
- R9: Every request gets `rsp_valid` one cycle later. Read data is taken from the register values before that clock edge. A read of an unmapped word address returns zero.
- R10: The enable register sits at word address 0. It reads back the written value in its low NUM_SRC bits, and the bits above those read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | NUM_SRC | Per-source illegal-access pulse |
| src_cid | input | NUM_SRC*CID_W | Per-source CID of the offending access |
| src_sec | input | NUM_SRC | Per-source secure flag of the offending access |
| src_priv | input | NUM_SRC | Per-source privilege flag of the offending access |
| src_wr | input | NUM_SRC | Per-source direction of the offending access (1 = write) |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 32 | Write data |
| req_cid | input | CID_W | CID of the requester |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | Interrupt toward the trusted processor |

## Verification
The hardest situation to reach is a clear that empties the pending register in the same cycle that a new enabled pulse arrives. That is the only case where a valid detail record is replaced rather than held. The directed phase builds it explicitly, and it also builds simultaneous pulses on several sources and pulses on masked sources. The random phase then mixes sparse pulses, changing enables, write-one-to-clear writes and requests from untrusted compartments, so that clears and pulses coincide often and in many combinations.

// File: rtl/afc_pkg.sv
package afc_pkg;

  localparam int REG_W = 32;

  // word addresses of the register port
  localparam int ADDR_ENABLE  = 0;
  localparam int ADDR_PENDING = 1;
  localparam int ADDR_DETAIL  = 2;

  // detail word field positions
  localparam int DET_IDX_LSB   = 0;
  localparam int DET_CID_LSB   = 8;
  localparam int DET_SEC_BIT   = 16;
  localparam int DET_PRIV_BIT  = 17;
  localparam int DET_WR_BIT    = 18;
  localparam int DET_VALID_BIT = 31;

  typedef struct packed {
    logic       valid;
    logic       wr;
    logic       priv;
    logic       sec;
    logic [7:0] cid;
    logic [7:0] idx;
  } fault_rec_t;

  function automatic logic [REG_W-1:0] pack_detail(input fault_rec_t r);
    logic [REG_W-1:0] w;
    w = '0;
    w[DET_IDX_LSB +: 8]  = r.idx;
    w[DET_CID_LSB +: 8]  = r.cid;
    w[DET_SEC_BIT]       = r.sec;
    w[DET_PRIV_BIT]      = r.priv;
    w[DET_WR_BIT]        = r.wr;
    w[DET_VALID_BIT]     = r.valid;
    return w;
  endfunction

  // index of the lowest set bit; zero when none is set
  function automatic logic [7:0] lowest_set(input logic [REG_W-1:0] v);
    logic [7:0] r;
    r = '0;
    for (int i = REG_W - 1; i >= 0; i--) begin
      if (v[i]) r = 8'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/afc_reg_port.sv
module afc_reg_port
  import afc_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int CID_W   = 3,
  parameter int ADDR_W  = 4,
  parameter logic [CID_W-1:0] TRUSTED_CID = 3'd5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [REG_W-1:0]   req_wdata,
  input  logic [CID_W-1:0]   req_cid,
  input  logic [NUM_SRC-1:0] pend_q,
  input  logic [REG_W-1:0]   det_word,
  output logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0] clr_mask,
  output logic               acc_ok,
  output logic               rsp_valid,
  output logic [REG_W-1:0]   rsp_rdata
);

  logic             wr_ok;
  logic             rd_ok;
  logic             en_we;
  logic [REG_W-1:0] rd_word;
  logic             unused_wdata_hi;

  assign acc_ok = req_valid && (req_cid == TRUSTED_CID);
  assign wr_ok  = acc_ok && req_write;
  assign rd_ok  = acc_ok && !req_write;
  assign en_we  = wr_ok && (req_addr == ADDR_W'(ADDR_ENABLE));
  assign clr_mask = (wr_ok && (req_addr == ADDR_W'(ADDR_PENDING)))
                    ? req_wdata[NUM_SRC-1:0] : '0;
  assign unused_wdata_hi = ^req_wdata[REG_W-1:NUM_SRC];

  always_comb begin
    rd_word = '0;
    if (rd_ok) begin
      if (req_addr == ADDR_W'(ADDR_ENABLE))       rd_word = REG_W'(en_q);
      else if (req_addr == ADDR_W'(ADDR_PENDING)) rd_word = REG_W'(pend_q);
      else if (req_addr == ADDR_W'(ADDR_DETAIL))  rd_word = det_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (en_we) en_q <= req_wdata[NUM_SRC-1:0];
      rsp_valid <= req_valid;
      rsp_rdata <= rd_word;
    end
  end

endmodule

// File: rtl/afc_pending.sv
module afc_pending #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_evt,
  input  logic [NUM_SRC-1:0] en_q,
  input  logic [NUM_SRC-1:0] clr_mask,
  output logic [NUM_SRC-1:0] ev_set,
  output logic [NUM_SRC-1:0] pend_kept,
  output logic [NUM_SRC-1:0] pend_next,
  output logic [NUM_SRC-1:0] pend_q
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    assign ev_set[i]    = src_evt[i] & en_q[i];
    assign pend_kept[i] = pend_q[i] & ~clr_mask[i];
    assign pend_next[i] = pend_kept[i] | ev_set[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= pend_next[i];
    end
  end

endmodule

// File: rtl/afc_capture.sv
module afc_capture
  import afc_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int CID_W   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       ev_set,
  input  logic [NUM_SRC-1:0]       pend_kept,
  input  logic [NUM_SRC-1:0]       pend_next,
  input  logic [NUM_SRC*CID_W-1:0] src_cid,
  input  logic [NUM_SRC-1:0]       src_sec,
  input  logic [NUM_SRC-1:0]       src_priv,
  input  logic [NUM_SRC-1:0]       src_wr,
  output logic                     capture_fire,
  output logic                     det_valid,
  output logic [REG_W-1:0]         det_word
);

  fault_rec_t det_q;
  fault_rec_t cand;
  logic [7:0] win_idx;

  assign win_idx      = lowest_set(REG_W'(ev_set));
  assign capture_fire = (|ev_set) && !(|pend_kept);

  always_comb begin
    cand       = '0;
    cand.valid = 1'b1;
    cand.idx   = win_idx;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (8'(i) == win_idx) begin
        cand.cid[CID_W-1:0] = src_cid[i*CID_W +: CID_W];
        cand.sec            = src_sec[i];
        cand.priv           = src_priv[i];
        cand.wr             = src_wr[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               det_q <= '0;
    else if (capture_fire)    det_q <= cand;
    else if (!(|pend_next))   det_q <= '0;
  end

  assign det_valid = det_q.valid;
  assign det_word  = pack_detail(det_q);

endmodule

// File: rtl/access_fault_ctrl.sv
module access_fault_ctrl
  import afc_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int CID_W   = 3,
  parameter int ADDR_W  = 4,
  parameter logic [CID_W-1:0] TRUSTED_CID = 3'd5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       src_evt,
  input  logic [NUM_SRC*CID_W-1:0] src_cid,
  input  logic [NUM_SRC-1:0]       src_sec,
  input  logic [NUM_SRC-1:0]       src_priv,
  input  logic [NUM_SRC-1:0]       src_wr,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [REG_W-1:0]         req_wdata,
  input  logic [CID_W-1:0]         req_cid,
  output logic                     rsp_valid,
  output logic [REG_W-1:0]         rsp_rdata,
  output logic                     irq
);

  // named internal events, also watched by the checker
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] clr_mask;
  logic [NUM_SRC-1:0] ev_set;
  logic [NUM_SRC-1:0] pend_kept;
  logic [NUM_SRC-1:0] pend_next;
  logic [NUM_SRC-1:0] pend_q;
  logic               acc_ok;
  logic               capture_fire;
  logic               det_valid;
  logic [REG_W-1:0]   det_word;

  afc_reg_port #(
    .NUM_SRC(NUM_SRC), .CID_W(CID_W), .ADDR_W(ADDR_W), .TRUSTED_CID(TRUSTED_CID)
  ) u_port (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_cid(req_cid),
    .pend_q(pend_q), .det_word(det_word),
    .en_q(en_q), .clr_mask(clr_mask), .acc_ok(acc_ok),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  afc_pending #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .src_evt(src_evt), .en_q(en_q), .clr_mask(clr_mask),
    .ev_set(ev_set), .pend_kept(pend_kept), .pend_next(pend_next), .pend_q(pend_q)
  );

  afc_capture #(.NUM_SRC(NUM_SRC), .CID_W(CID_W)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .ev_set(ev_set), .pend_kept(pend_kept), .pend_next(pend_next),
    .src_cid(src_cid), .src_sec(src_sec), .src_priv(src_priv), .src_wr(src_wr),
    .capture_fire(capture_fire), .det_valid(det_valid), .det_word(det_word)
  );

  assign irq = |(pend_q & en_q);

endmodule

// File: rtl/afc_checker.sv
module afc_checker
  import afc_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int CID_W   = 3,
  parameter int ADDR_W  = 4,
  parameter logic [CID_W-1:0] TRUSTED_CID = 3'd5
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_evt,
  input logic               req_valid,
  input logic               req_write,
  input logic [CID_W-1:0]   req_cid,
  input logic               rsp_valid,
  input logic [REG_W-1:0]   rsp_rdata,
  input logic [NUM_SRC-1:0] en_q,
  input logic [NUM_SRC-1:0] pend_q,
  input logic [NUM_SRC-1:0] pend_kept,
  input logic               det_valid,
  input logic [REG_W-1:0]   det_word
);

  logic foreign_req;
  assign foreign_req = req_valid && (req_cid != TRUSTED_CID);

  p_enabled_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_evt & en_q) != '0) |=> ((pend_q & $past(src_evt & en_q)) == $past(src_evt & en_q)));

  p_no_spurious_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(src_evt & en_q)) == '0));

  p_detail_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (det_valid && (pend_kept != '0)) |=> $stable(det_word));

  p_detail_tracks_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    det_valid == (pend_q != '0));

  p_foreign_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (foreign_req && !req_write) |=> (rsp_rdata == '0));

  p_foreign_write_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (foreign_req && req_write) |=> $stable(en_q));

  p_rsp_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rsp_valid == $past(req_valid)));

endmodule

bind access_fault_ctrl afc_checker #(
  .NUM_SRC(NUM_SRC), .CID_W(CID_W), .ADDR_W(ADDR_W), .TRUSTED_CID(TRUSTED_CID)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_evt(src_evt),
  .req_valid(req_valid), .req_write(req_write), .req_cid(req_cid),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .en_q(en_q), .pend_q(pend_q), .pend_kept(pend_kept),
  .det_valid(det_valid), .det_word(det_word)
);

// File: tb/tb_access_fault_ctrl.sv
module tb_access_fault_ctrl;

  localparam int N  = 16;
  localparam int CW = 3;
  localparam int AW = 4;
  localparam logic [CW-1:0] TCID = 3'd5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src_evt = '0;
  logic [N*CW-1:0] src_cid = '0;
  logic [N-1:0]  src_sec = '0, src_priv = '0, src_wr = '0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic [CW-1:0] req_cid = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic          irq;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] m_en = '0, m_pend = '0;
  logic [31:0]  m_det = '0;

  always #10 clk = ~clk;

  access_fault_ctrl #(.NUM_SRC(N), .CID_W(CW), .ADDR_W(AW), .TRUSTED_CID(TCID)) dut (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .src_cid(src_cid),
    .src_sec(src_sec), .src_priv(src_priv), .src_wr(src_wr),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_cid(req_cid),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  function automatic logic [31:0] detail_of(input int idx, input logic [CW-1:0] c,
                                             input logic s, input logic p, input logic w);
    logic [31:0] d;
    d = 32'h8000_0000 | (32'(w) << 18) | (32'(p) << 17) | (32'(s) << 16)
        | (32'(c) << 8) | 32'(idx);
    return d;
  endfunction

  function automatic int first_one(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_src(input int i, input logic [CW-1:0] c, input logic s,
                         input logic p, input logic w);
    src_cid[i*CW +: CW] = c;
    src_sec[i] = s; src_priv[i] = p; src_wr[i] = w;
  endtask

  // one clock of stimulus with model update and output checks
  task automatic step(input logic [N-1:0] evt, input bit rv, input bit rw,
                      input logic [AW-1:0] ad, input logic [31:0] wd,
                      input logic [CW-1:0] rc, input string tag);
    logic [N-1:0] en_n, clr, setv, kept, pend_n;
    logic [31:0]  det_n, exp_rd;
    bit acc;
    int k;
    src_evt = evt; req_valid = rv; req_write = rw; req_addr = ad;
    req_wdata = wd; req_cid = rc;
    acc    = rv && (rc == TCID);
    exp_rd = '0;
    if (acc && !rw) begin
      if (ad == 0)      exp_rd = 32'(m_en);
      else if (ad == 1) exp_rd = 32'(m_pend);
      else if (ad == 2) exp_rd = m_det;
    end
    en_n   = (acc && rw && ad == 0) ? wd[N-1:0] : m_en;
    clr    = (acc && rw && ad == 1) ? wd[N-1:0] : '0;
    setv   = evt & m_en;
    kept   = m_pend & ~clr;
    pend_n = kept | setv;
    det_n  = m_det;
    if (setv != '0 && kept == '0) begin
      k = first_one(setv);
      det_n = detail_of(k, src_cid[k*CW +: CW], src_sec[k], src_priv[k], src_wr[k]);
    end else if (pend_n == '0) begin
      det_n = '0;
    end
    @(posedge clk);
    m_en = en_n; m_pend = pend_n; m_det = det_n;
    @(negedge clk);
    src_evt = '0; req_valid = 1'b0; req_write = 1'b0;
    check(irq == |(m_pend & m_en), {tag, " irq (R3)"}, 32'(irq), 32'(|(m_pend & m_en)));
    check(rsp_valid == rv, {tag, " rsp_valid (R9)"}, 32'(rsp_valid), 32'(rv));
    if (rv && !rw) check(rsp_rdata == exp_rd, {tag, " rdata"}, rsp_rdata, exp_rd);
  endtask

  task automatic rd(input logic [AW-1:0] ad, input string tag);
    step('0, 1'b1, 1'b0, ad, '0, TCID, tag);
  endtask

  task automatic wr(input logic [AW-1:0] ad, input logic [31:0] wd, input string tag);
    step('0, 1'b1, 1'b1, ad, wd, TCID, tag);
  endtask

  task automatic idle(input logic [N-1:0] evt, input string tag);
    step(evt, 1'b0, 1'b0, '0, '0, TCID, tag);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) set_src(i, CW'(i), i[0], i[1], i[2]);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(irq == 1'b0, "R1 irq after reset", 32'(irq), 0);
    rd(0, "R1 enable"); rd(1, "R1 pending"); rd(2, "R1 detail");

    wr(0, 32'hFFFF_FFFF, "R10 write all"); rd(0, "R10 readback masked");
    wr(0, 32'h0000_00FF, "R10 write low"); rd(0, "R10 readback");

    idle(16'h0200, "R2 masked pulse"); rd(1, "R2 masked pending");
    set_src(3, 3'd6, 1'b1, 1'b0, 1'b1);
    idle(16'h0008, "R2 enabled pulse"); rd(1, "R2 pending"); rd(2, "R5 first detail");
    idle(16'h0020, "R5 second pulse"); rd(1, "R5 pending"); rd(2, "R5 detail held");
    wr(0, 32'h0, "R3 mask all"); rd(1, "R3 pending kept");
    wr(0, 32'h0000_00FF, "R3 unmask");
    wr(1, 32'h0000_0008, "R4 clear one"); rd(1, "R4 pending"); rd(2, "R5 still held");
    wr(1, 32'h0, "R4 write zero"); rd(1, "R4 unchanged");
    wr(1, 32'h0000_0020, "R7 clear last"); rd(2, "R7 detail zero");
    idle(16'h0044, "R6 simultaneous"); rd(2, "R6 lowest index");
    set_src(7, 3'd2, 1'b0, 1'b1, 1'b0);
    step(16'h0080, 1'b1, 1'b1, 4'd1, 32'h0000_FFFF, TCID, "R7 clear with pulse");
    rd(2, "R7 new capture"); rd(1, "R7 pending");

    step('0, 1'b1, 1'b1, 4'd0, 32'h0, 3'd1, "R8 foreign enable write");
    step('0, 1'b1, 1'b1, 4'd1, 32'hFFFF, 3'd2, "R8 foreign clear");
    rd(0, "R8 enable kept"); rd(1, "R8 pending kept");
    step('0, 1'b1, 1'b0, 4'd1, 32'h0, 3'd0, "R8 foreign read");
    rd(3, "R9 unmapped"); rd(4'hF, "R9 unmapped high");

    void'($urandom(32'd1234));
    for (int n = 0; n < 600; n++) begin
      logic [N-1:0] e;
      logic [AW-1:0] a;
      logic [CW-1:0] c;
      int r;
      for (int i = 0; i < N; i++)
        set_src(i, CW'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      e = '0;
      if ($urandom_range(0, 3) == 0) e[$urandom_range(0, N-1)] = 1'b1;
      if ($urandom_range(0, 7) == 0) e[$urandom_range(0, N-1)] = 1'b1;
      a = AW'($urandom_range(0, 3));
      c = ($urandom_range(0, 4) == 0) ? CW'($urandom) : TCID;
      r = $urandom_range(0, 3);
      if (r == 0)      step(e, 1'b0, 1'b0, a, '0, c, "mixed idle");
      else if (r == 1) step(e, 1'b1, 1'b0, a, '0, c, "mixed read");
      else             step(e, 1'b1, 1'b1, a, $urandom, c, "mixed write");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule